// File: doc/BRIEF.md
# Serial EEPROM Host Controller (three-wire, 64 x 16)

This block is the master side of a three-wire serial link to a 64-word by 16-bit electrically erasable memory. A single request port takes a command code, a 6-bit word address and a 16-bit write word. The controller then drives chip select (CS), a serial clock (SK) and the serial data line toward the memory (DI). It samples the memory's data output (DO) and returns read data together with a one-cycle done strobe.

The serial clock comes from the system clock through a programmable divider. For each command the controller builds the bit frame: a start bit, a two-bit opcode, six address or selector bits and, where the command needs it, sixteen data bits. On reads it throws away the leading dummy zero. After any programming command it drops CS for a minimum time, raises CS again and polls DO until the memory reports ready. If ready does not arrive within a set number of polls, the request finishes with an error.

When the auto-protect option is on, every programming command is wrapped between a write-enable frame and a write-disable frame. This matters because the memory starts up write-protected.

Top module: `mw_host`

## Requirements
- R1: After reset, CS and SK are low, DI is low, and busy, done and err are all low.
- R2: Every frame begins with a start bit of 1, then the opcode (READ 10, WRITE 01, ERASE 11, extended 00), then six bits MSB first. These six bits are the address for READ/WRITE/ERASE. For extended frames the top two bits select EWEN 11, EWDS 00, ERAL 10, WRAL 01 and the other four bits are 0.
- R3: READ, WRITE and WRAL frames carry exactly 25 SK rising edges. ERASE, EWEN, EWDS and ERAL frames carry exactly 9.
- R4: On READ, the DO bit that follows the last address bit is discarded. The next 16 DO bits, MSB first, become rd_data, which is valid when done is high.
- R5: On WRITE and WRAL, the 16 data bits follow the address on DI, MSB first.
- R6: With AUTO_PROTECT=1, each programming command (WRITE, ERASE, ERAL, WRAL) is preceded by an EWEN frame and followed by an EWDS frame, so the memory is write-disabled again when done fires.
- R7: After a programming frame, CS goes low and then high again. DI is held low while status is polled, and done does not fire before DO has read 1 (ready).
- R8: If DO stays 0 for MAX_POLLS polls, the request ends with done and err both high.
- R9: busy rises in the cycle after a request is accepted and falls in the cycle after done. A request presented while busy is high is ignored. CS stays low while busy is low.
- R10: SK toggles only while CS is high, every SK level lasts at least DIV system clocks, and DI changes only while SK is low.
- R11: Between two CS-high periods, CS stays low for at least CS_LOW_CYC system clocks.
- R12: The unused command code 7 produces done with err in the cycle after acceptance, with no CS activity.
- R13: done is a one-cycle pulse, and err is high only together with done.

Command codes on req_cmd: 0 READ, 1 WRITE, 2 ERASE, 3 EWEN, 4 EWDS, 5 ERAL, 6 WRAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_cmd | input | 3 | Command code |
| req_addr | input | 6 | Word address |
| req_wdata | input | 16 | Write word for WRITE/WRAL |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Unsupported command or status timeout, with done |
| rd_data | output | 16 | Word from the last READ |
| mw_cs | output | 1 | Memory chip select |
| mw_sk | output | 1 | Memory serial clock |
| mw_di | output | 1 | Serial data toward memory |
| mw_do | input | 1 | Serial data / status from memory |

## Verification
The bench builds the controller with DIV=2, CS_LOW_CYC=3, MAX_POLLS=24 and AUTO_PROTECT=1. The short divider keeps full 25-clock frames to about a hundred system cycles. The small poll limit lets the bench's memory model hold DO busy forever and reach the timeout within a few dozen cycles, while its normal 30-cycle programming delay still needs several busy polls before ready. With auto-protect on, every programming request shows the full unlock, command, status and lock sequence on the wires.

// File: rtl/mw_pkg.sv
// Shared types and frame-building helpers for the serial EEPROM host.
// Assumes a 6-bit word address and a 16-bit data word.
package mw_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;
    localparam int HDR_W  = 3 + ADDR_W;

    typedef enum logic [2:0] {
        CMD_READ  = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_ERASE = 3'd2,
        CMD_EWEN  = 3'd3,
        CMD_EWDS  = 3'd4,
        CMD_ERAL  = 3'd5,
        CMD_WRAL  = 3'd6
    } mw_cmd_e;

    typedef enum logic [2:0] {S_IDLE, S_LAUNCH, S_RUN, S_GAP, S_POLL, S_END} mw_state_e;
    typedef enum logic [1:0] {P_UNLOCK, P_CMD, P_POLL, P_LOCK} mw_step_e;

    // Start bit, opcode and address/selector field for one command.
    function automatic logic [HDR_W-1:0] mw_header(input logic [2:0] cmd,
                                                   input logic [ADDR_W-1:0] addr);
        logic [ADDR_W-1:0] ext;
        ext = '0;
        case (cmd)
            CMD_READ:  return {1'b1, 2'b10, addr};
            CMD_WRITE: return {1'b1, 2'b01, addr};
            CMD_ERASE: return {1'b1, 2'b11, addr};
            CMD_EWEN:  ext[ADDR_W-1 -: 2] = 2'b11;
            CMD_ERAL:  ext[ADDR_W-1 -: 2] = 2'b10;
            CMD_WRAL:  ext[ADDR_W-1 -: 2] = 2'b01;
            default:   ext = '0;
        endcase
        return {1'b1, 2'b00, ext};
    endfunction

    function automatic logic mw_is_long(input logic [2:0] cmd);
        return (cmd == CMD_READ) || (cmd == CMD_WRITE) || (cmd == CMD_WRAL);
    endfunction

    function automatic logic mw_is_prog(input logic [2:0] cmd);
        return (cmd == CMD_WRITE) || (cmd == CMD_ERASE) ||
               (cmd == CMD_ERAL)  || (cmd == CMD_WRAL);
    endfunction

    function automatic logic mw_has_data(input logic [2:0] cmd);
        return (cmd == CMD_WRITE) || (cmd == CMD_WRAL);
    endfunction
endpackage

// File: rtl/mw_tick.sv
// Serial clock phase tick: one pulse every DIV system clocks while enabled.
// Assumes DIV >= 1; the count restarts whenever the enable is low.
module mw_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(DIV + 1);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(DIV - 1));

    // Count system clocks within one SK phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (tick)     cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mw_frame.sv
// Bit engine for one CS-high frame: shifts header and data out on DI,
// raises and lowers SK on successive ticks and captures DO at each falling
// SK when asked. Bit index HDR_W-1 is the dummy bit and is never stored.
// Assumes start arrives only while the engine is idle.
module mw_frame #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [ADDR_W+2:0] hdr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              long_frm,
    input  logic              capture,
    input  logic              do_in,
    output logic              cs,
    output logic              sk,
    output logic              di,
    output logic              fin,
    output logic [DATA_W-1:0] rdata
);
    localparam int HDR_W = ADDR_W + 3;
    localparam int FRM_W = HDR_W + DATA_W;
    localparam int CNT_W = $clog2(FRM_W + 1);

    logic [FRM_W-1:0] sr;
    logic [CNT_W-1:0] bitcnt;
    logic [CNT_W-1:0] last;
    logic             phase, run, long_q, cap_q;

    assign last = long_q ? CNT_W'(FRM_W - 1) : CNT_W'(HDR_W - 1);

    // Frame sequencing: load, rising phase, falling phase with capture and shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0; bitcnt <= '0; phase <= 1'b0; run <= 1'b0;
            long_q <= 1'b0; cap_q <= 1'b0;
            cs <= 1'b0; sk <= 1'b0; di <= 1'b0; fin <= 1'b0; rdata <= '0;
        end else begin
            fin <= 1'b0;
            if (start && !run) begin
                sr     <= {hdr, wdata};
                run    <= 1'b1;
                cs     <= 1'b1;
                sk     <= 1'b0;
                di     <= hdr[HDR_W-1];
                bitcnt <= '0;
                phase  <= 1'b0;
                long_q <= long_frm;
                cap_q  <= capture;
            end else if (run && tick) begin
                if (!phase) begin
                    sk    <= 1'b1;
                    phase <= 1'b1;
                end else begin
                    sk    <= 1'b0;
                    phase <= 1'b0;
                    if (cap_q && bitcnt >= CNT_W'(HDR_W))
                        rdata <= {rdata[DATA_W-2:0], do_in};
                    if (bitcnt == last) begin
                        run <= 1'b0;
                        cs  <= 1'b0;
                        di  <= 1'b0;
                        fin <= 1'b1;
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                        sr     <= {sr[FRM_W-2:0], 1'b0};
                        di     <= sr[FRM_W-2];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mw_host.sv
// Host controller for a 64 x 16 three-wire serial EEPROM. Accepts one request
// at a time, runs the unlock / command / status poll / lock sequence and
// reports done, err and read data. Assumes mw_do is synchronous to clk
// (pulled high by the board when the memory does not drive it).
module mw_host #(
    parameter int DIV          = 4,
    parameter int CS_LOW_CYC   = 4,
    parameter int MAX_POLLS    = 256,
    parameter bit AUTO_PROTECT = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [2:0]                 req_cmd,
    input  logic [mw_pkg::ADDR_W-1:0]  req_addr,
    input  logic [mw_pkg::DATA_W-1:0]  req_wdata,
    output logic                       busy,
    output logic                       done,
    output logic                       err,
    output logic [mw_pkg::DATA_W-1:0]  rd_data,
    output logic                       mw_cs,
    output logic                       mw_sk,
    output logic                       mw_di,
    input  logic                       mw_do
);
    import mw_pkg::*;

    localparam int GW = $clog2(CS_LOW_CYC + 1);
    localparam int PW = $clog2(MAX_POLLS + 1);

    mw_state_e           state;
    mw_step_e            step;
    logic [2:0]          cmd_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic                err_q;
    logic [GW-1:0]       gcnt;
    logic [PW-1:0]       pcnt;
    logic [2:0]          cur_cmd;
    logic                tick, frm_cs, frm_fin;

    // Command carried by the frame about to be launched.
    always_comb begin
        case (step)
            P_UNLOCK: cur_cmd = CMD_EWEN;
            P_LOCK:   cur_cmd = CMD_EWDS;
            default:  cur_cmd = cmd_q;
        endcase
    end

    mw_tick #(.DIV(DIV)) u_tick (
        .clk(clk), .rst_n(rst_n),
        .en(state == S_RUN || state == S_POLL),
        .tick(tick)
    );

    mw_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .start(state == S_LAUNCH),
        .hdr(mw_header(cur_cmd, addr_q)),
        .wdata(mw_has_data(cur_cmd) ? wdata_q : '0),
        .long_frm(mw_is_long(cur_cmd)),
        .capture(cur_cmd == CMD_READ),
        .do_in(mw_do),
        .cs(frm_cs), .sk(mw_sk), .di(mw_di), .fin(frm_fin),
        .rdata(rd_data)
    );

    assign mw_cs = frm_cs | (state == S_POLL);
    assign busy  = (state != S_IDLE);
    assign done  = (state == S_END);
    assign err   = done & err_q;

    // Request sequencing across frames, CS gaps and status polling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE; step <= P_CMD; cmd_q <= '0; addr_q <= '0;
            wdata_q <= '0; err_q <= 1'b0; gcnt <= '0; pcnt <= '0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    cmd_q   <= req_cmd;
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    err_q   <= 1'b0;
                    if (req_cmd == 3'd7) begin
                        err_q <= 1'b1;
                        state <= S_END;
                    end else begin
                        step  <= (AUTO_PROTECT && mw_is_prog(req_cmd)) ? P_UNLOCK : P_CMD;
                        state <= S_LAUNCH;
                    end
                end
                S_LAUNCH: state <= S_RUN;
                S_RUN: if (frm_fin) begin
                    gcnt  <= '0;
                    state <= S_GAP;
                end
                S_GAP: begin
                    gcnt <= gcnt + 1'b1;
                    if (gcnt == GW'(CS_LOW_CYC - 1)) begin
                        case (step)
                            P_UNLOCK: begin step <= P_CMD; state <= S_LAUNCH; end
                            P_CMD: if (mw_is_prog(cmd_q)) begin
                                step <= P_POLL; pcnt <= '0; state <= S_POLL;
                            end else state <= S_END;
                            P_POLL: if (AUTO_PROTECT) begin
                                step <= P_LOCK; state <= S_LAUNCH;
                            end else state <= S_END;
                            default: state <= S_END;
                        endcase
                    end
                end
                S_POLL: if (tick) begin
                    gcnt <= '0;
                    if (mw_do) state <= S_GAP;
                    else if (pcnt == PW'(MAX_POLLS - 1)) begin
                        err_q <= 1'b1;
                        state <= S_GAP;
                    end else pcnt <= pcnt + 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mw_host_chk.sv
// Protocol checker for mw_host, attached by bind. Watches only the ports.
module mw_host_chk #(
    parameter int DIV        = 4,
    parameter int CS_LOW_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic err,
    input logic mw_cs,
    input logic mw_sk,
    input logic mw_di
);
    logic [15:0] low_cnt, run_cnt;
    logic        sk_prev;

    // Cycles CS has been low, and cycles SK has held its level (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= 16'(CS_LOW_CYC);
            run_cnt <= 16'(DIV);
            sk_prev <= 1'b0;
        end else begin
            sk_prev <= mw_sk;
            if (mw_cs) low_cnt <= '0;
            else if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 1'b1;
            if (mw_sk != sk_prev) run_cnt <= 16'd1;
            else if (run_cnt != 16'hFFFF) run_cnt <= run_cnt + 1'b1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mw_cs && !mw_sk));
    p_sk_needs_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mw_cs |-> !mw_sk);
    p_di_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mw_sk |-> $stable(mw_di));
    p_sk_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_sk != sk_prev) |-> (run_cnt >= 16'(DIV)));
    p_cs_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mw_cs) |-> (low_cnt >= 16'(CS_LOW_CYC)));
    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_err_with_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    p_busy_until_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

bind mw_host mw_host_chk #(.DIV(DIV), .CS_LOW_CYC(CS_LOW_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
    .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di)
);

// File: tb/mw_host_tb_top.sv
module mw_host_tb_top;
    localparam int DIV = 2, CSL = 3, MAXP = 24, BUSY_T = 30;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_cmd = '0;
    logic [5:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic busy, done, err, mw_cs, mw_sk, mw_di, mw_do;
    logic [15:0] rd_data;

    always #10 clk = ~clk;

    mw_host #(.DIV(DIV), .CS_LOW_CYC(CSL), .MAX_POLLS(MAXP), .AUTO_PROTECT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .err(err), .rd_data(rd_data), .mw_cs(mw_cs), .mw_sk(mw_sk),
        .mw_di(mw_di), .mw_do(mw_do));

    int checks = 0, bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural memory model ----------------
    logic [15:0] mem [64];
    bit   we_en = 0, stuck = 0, rd_drive = 1, in_status = 0, expect_status = 0;
    int   nbits = 0, cyc_now = 0, busy_until = 0, status_periods = 0;
    logic [24:0] sh = '0;
    logic [8:0]  hdr_cur = '0;
    logic [15:0] rd_word = '0;
    logic [8:0]  hdr_q[$];
    int          len_q[$];

    assign mw_do = !mw_cs ? 1'b1 : in_status ? !(stuck || cyc_now < busy_until) : rd_drive;

    always @(posedge clk) cyc_now++;

    always @(posedge mw_cs) begin
        nbits = 0;
        in_status = expect_status;
        expect_status = 0;
        if (in_status) status_periods++;
    end

    always @(posedge mw_sk) if (mw_cs && !in_status) begin
        sh = {sh[23:0], mw_di};
        nbits++;
        if (nbits == 9) begin
            hdr_cur = sh[8:0];
            if (sh[7:6] == 2'b10) begin rd_word = mem[sh[5:0]]; rd_drive = 0; end
        end else if (nbits > 9 && nbits <= 25 && hdr_cur[7:6] == 2'b10)
            rd_drive = rd_word[25 - nbits];
    end

    always @(negedge mw_cs) begin
        in_status = 0;
        rd_drive = 1;
        if (nbits > 0) begin
            hdr_q.push_back(hdr_cur);
            len_q.push_back(nbits);
            case (hdr_cur[7:6])
                2'b01: begin expect_status = 1;
                    if (we_en) begin mem[hdr_cur[5:0]] = sh[15:0]; busy_until = cyc_now + BUSY_T; end end
                2'b11: begin expect_status = 1;
                    if (we_en) begin mem[hdr_cur[5:0]] = 16'hFFFF; busy_until = cyc_now + BUSY_T; end end
                2'b00: case (hdr_cur[5:4])
                    2'b11: we_en = 1;
                    2'b00: we_en = 0;
                    2'b10: begin expect_status = 1;
                        if (we_en) begin for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF; busy_until = cyc_now + BUSY_T; end end
                    default: begin expect_status = 1;
                        if (we_en) begin for (int i = 0; i < 64; i++) mem[i] = sh[15:0]; busy_until = cyc_now + BUSY_T; end end
                endcase
                default: ;
            endcase
        end
    end

    // ---------------- per-clock reference and monitors ----------------
    bit ref_busy = 0;
    int sk_run = 100, cs_low_run = 100, sk_viol = 0, gap_viol = 0, di_viol = 0, skcs_viol = 0;
    logic sk_prev = 0, cs_prev = 0;

    always @(posedge clk) begin
        if (!rst_n) ref_busy <= 0;
        else if (ref_busy && done) ref_busy <= 0;
        else if (!ref_busy && req_valid) ref_busy <= 1;
    end

    always @(negedge clk) if (rst_n) begin
        chk("R9 busy per-clock", busy, ref_busy);
        if (mw_sk != sk_prev) begin if (sk_run < DIV) sk_viol++; sk_run = 1; end else sk_run++;
        if (mw_cs && !cs_prev && cs_low_run < CSL) gap_viol++;
        if (mw_cs) cs_low_run = 0; else cs_low_run++;
        if (mw_cs && in_status && mw_di) di_viol++;
        if (!mw_cs && mw_sk) skcs_viol++;
        sk_prev = mw_sk; cs_prev = mw_cs;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected<=150000", wd);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    logic [15:0] r_rd; logic r_err; int r_cyc;

    task automatic run_op(input int cmd, input int addr, input int wd_in);
        hdr_q.delete(); len_q.delete();
        @(negedge clk);
        req_valid = 1; req_cmd = 3'(cmd); req_addr = 6'(addr); req_wdata = 16'(wd_in);
        @(negedge clk);
        req_valid = 0;
        r_cyc = 1;
        while (!done && r_cyc < 20000) begin @(negedge clk); r_cyc++; end
        r_rd = rd_data; r_err = err;
    endtask

    task automatic chk_frame(input string tag, input int idx, input logic [8:0] hdr, input int len);
        chk(tag, (hdr_q.size() > idx) ? 32'(hdr_q[idx]) : 32'hDEAD, 32'(hdr));
        chk(tag, (len_q.size() > idx) ? 32'(len_q[idx]) : 32'hDEAD, 32'(len));
    endtask

    initial begin
        int sp;
        for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        chk("R1 cs after reset", mw_cs, 0);
        chk("R1 sk after reset", mw_sk, 0);
        chk("R1 busy/done/err after reset", {busy, done, err, mw_di}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // WRITE with auto unlock/lock and status polling
        sp = status_periods;
        run_op(1, 5, 16'hA5C3);
        chk("R5 write stored MSB first", mem[5], 16'hA5C3);
        chk("R6 frame count", hdr_q.size(), 3);
        chk_frame("R6 unlock frame R2 R3", 0, 9'b1_00_110000, 9);
        chk_frame("R2 write header R3 len", 1, 9'b1_01_000101, 25);
        chk_frame("R6 lock frame", 2, 9'b1_00_000000, 9);
        chk("R6 memory locked after", we_en, 0);
        chk("R7 one status period", status_periods - sp, 1);
        chk("R7 done only when ready", (cyc_now >= busy_until), 1);
        chk("R7 no error", r_err, 0);

        // READ back with dummy discard
        sp = status_periods;
        run_op(0, 5, 0);
        chk("R4 read data", r_rd, 16'hA5C3);
        chk_frame("R2 read header R3 len", 0, 9'b1_10_000101, 25);
        chk("R7 no status on read", status_periods - sp, 0);

        // Edge bits at top address
        run_op(1, 63, 16'h8001);
        chk("R5 write top address", mem[63], 16'h8001);
        run_op(0, 63, 0);
        chk("R4 read edge bits", r_rd, 16'h8001);

        // ERASE
        run_op(2, 5, 0);
        chk_frame("R2 erase header R3 len", 1, 9'b1_11_000101, 9);
        chk("R6 erase wrapped", hdr_q.size(), 3);
        run_op(0, 5, 0);
        chk("R4 read erased", r_rd, 16'hFFFF);

        // WRAL
        run_op(6, 0, 16'h1234);
        chk_frame("R2 wral header R3 len", 1, 9'b1_00_010000, 25);
        run_op(0, 40, 0);
        chk("R5 wral data", r_rd, 16'h1234);

        // ERAL
        run_op(5, 0, 0);
        chk_frame("R2 eral header R3 len", 1, 9'b1_00_100000, 9);
        run_op(0, 17, 0);
        chk("R4 read after eral", r_rd, 16'hFFFF);

        // Explicit EWEN / EWDS
        run_op(3, 0, 0);
        chk_frame("R2 ewen header R3 len", 0, 9'b1_00_110000, 9);
        chk("R2 ewen enables", we_en, 1);
        run_op(4, 0, 0);
        chk_frame("R2 ewds header R3 len", 0, 9'b1_00_000000, 9);
        chk("R2 ewds disables", we_en, 0);

        // Request while busy is ignored
        hdr_q.delete(); len_q.delete();
        @(negedge clk);
        req_valid = 1; req_cmd = 3'd0; req_addr = 6'd63;
        @(negedge clk);
        req_valid = 0;
        repeat (3) @(negedge clk);
        req_valid = 1; req_cmd = 3'd1; req_addr = 6'd63; req_wdata = 16'h0000;
        @(negedge clk);
        req_valid = 0;
        r_cyc = 0;
        while (!done && r_cyc < 20000) begin @(negedge clk); r_cyc++; end
        chk("R4 read during ignore test", rd_data, 16'hFFFF);
        repeat (4) @(negedge clk);
        chk("R9 ignored request made no frame", hdr_q.size(), 1);
        chk("R9 cs low when idle", mw_cs, 0);
        chk("R9 memory untouched", mem[63], 16'hFFFF);

        // Unsupported code
        run_op(7, 0, 0);
        chk("R12 err with done", r_err, 1);
        chk("R12 done next cycle", r_cyc, 1);
        chk("R12 no frames", hdr_q.size(), 0);
        @(negedge clk);
        chk("R13 done is one cycle", done, 0);

        // Status timeout
        stuck = 1;
        run_op(1, 1, 16'h5555);
        chk("R8 timeout err", r_err, 1);
        chk("R6 lock still issued", hdr_q.size(), 3);
        stuck = 0;
        run_op(0, 2, 0);
        chk("R13 err clears on next request", r_err, 0);

        chk("R10 sk level length", sk_viol, 0);
        chk("R10 sk only with cs", skcs_viol, 0);
        chk("R11 cs low gap", gap_viol, 0);
        chk("R7 di low during status", di_viol, 0);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule